// File: doc/BRIEF.md
# Warp Access Coalescer

This block takes one load or store request from a 32-lane warp and turns it into the shortest list of naturally aligned memory transactions that covers it. Each request carries an address for every lane, an active-lane mask and one access width (1, 2, 4 or 8 bytes) that applies to all lanes. The block returns a stream of descriptors. Each descriptor gives a segment base address, a segment size of 32, 64 or 128 bytes, and the set of lanes the segment serves. Descriptors are handed off over a valid/ready pair.

After a request is accepted, the block scans the lanes in groups of eight and spends one cycle on each group that holds an active lane. Empty groups cost nothing. It then emits one descriptor for each distinct 128-byte line touched, lowest address first. Each descriptor is shrunk to the smallest aligned 32- or 64-byte segment inside its line that still covers every byte its lanes access. A pulse on `done` marks the end of each request.

Top module: `cwc_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and both `txn_valid` and `done` are 0.
- R2: `req_size` selects the per-lane access width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. The address bits below that width are ignored, so a lane's access starts at its address rounded down to a multiple of the width.
- R3: `txn_size` encodes the segment size: 0 means 32 bytes, 1 means 64 bytes and 2 means 128 bytes. The value 3 never appears, and `txn_base` is always a multiple of the encoded size.
- R4: Exactly one descriptor is issued for each distinct 128-byte aligned line touched by an active lane. Bit k of `txn_lanes` is set exactly when lane k is active and its access lies in that line, and inactive lanes never appear.
- R5: Each descriptor uses the smallest aligned segment of 32, 64 or 128 bytes within its line that covers every byte accessed by the lanes it serves.
- R6: Descriptors come out in strictly ascending `txn_base` order, one per cycle while `txn_ready` is high. `txn_last` is 1 only on the final descriptor of a request.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, the descriptor (`txn_base`, `txn_size`, `txn_lanes`) stays unchanged and valid.
- R8: The first descriptor becomes valid exactly k clock edges after the acceptance edge, where k is the number of 8-lane groups (lanes 0-7, 8-15, 16-23, 24-31) that contain an active lane.
- R9: A request with an all-zero mask produces no descriptor. `done` is 1 for exactly the one cycle that follows the acceptance edge.
- R10: `req_ready` stays 0 from acceptance until the last descriptor has been handed off. `done` is then 1 for exactly the one cycle after that handoff edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge if valid |
| req_addr | input | LANES*ADDR_W | Lane addresses, lane k at bits k*ADDR_W upward |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 2 | Per-lane access width code |
| txn_valid | output | 1 | Descriptor offered |
| txn_ready | input | 1 | Descriptor taken on this edge if valid |
| txn_base | output | ADDR_W | Segment base address |
| txn_size | output | 2 | Segment size code |
| txn_lanes | output | LANES | Lanes served by the segment |
| txn_last | output | 1 | Final descriptor of the request |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench builds the block with its default parameters: 32 lanes, groups of eight and 32-bit addresses. This gives four groups, so every scan latency from one to four cycles can be reached, and the address range is wide enough to place the lanes of one request in many separate 128-byte lines. Directed patterns cover each access width and every segment size. They also cover lanes placed in reverse address order across 32 lines, misaligned lane addresses, masks that skip whole groups, an empty mask, and output stalls.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  // log2 of the 128-byte line
  localparam int LINE_LG = 7;

  typedef enum logic [1:0] {
    SEG32  = 2'd0,
    SEG64  = 2'd1,
    SEG128 = 2'd2
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2
  } state_e;

  // bytes touched by one lane for a width code
  function automatic logic [3:0] lane_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // low address bits cleared by the natural alignment of a lane
  function automatic logic [2:0] low_mask(input logic [1:0] code);
    return 3'((4'd1 << code) - 4'd1);
  endfunction

  // offset of the final byte a lane touches inside its line
  function automatic logic [6:0] last_off(input logic [6:0] off, input logic [1:0] code);
    return off + {3'd0, lane_bytes(code)} - 7'd1;
  endfunction

  // smallest aligned segment holding byte range lo..hi of one line
  function automatic seg_e seg_fit(input logic [6:0] lo, input logic [6:0] hi);
    if (lo[6:5] == hi[6:5]) return SEG32;
    if (lo[6] == hi[6])     return SEG64;
    return SEG128;
  endfunction

  // in-line offset of the chosen segment
  function automatic logic [6:0] seg_off(input logic [6:0] lo, input seg_e s);
    case (s)
      SEG32:   return {lo[6:5], 5'd0};
      SEG64:   return {lo[6], 6'd0};
      default: return 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/cwc_group_pick.sv
module cwc_group_pick #(
  parameter int NG = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic [NG-1:0] grp_any,
  input  logic [GW:0]   from,
  output logic          found,
  output logic [GW-1:0] idx
);
  // lowest non-empty group at or above 'from'
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_any[g] && ((GW+1)'(g) >= from)) begin
        found = 1'b1;
        idx   = GW'(g);
      end
    end
  end
endmodule

// File: rtl/cwc_line_min.sv
module cwc_line_min #(
  parameter int LANES = 32,
  parameter int LW    = 25
) (
  input  logic [LANES*LW-1:0] lines_flat,
  input  logic [LANES-1:0]    pend,
  output logic [LW-1:0]       min_line,
  output logic [LANES-1:0]    sel
);
  logic [LW-1:0] line [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign line[l] = lines_flat[l*LW +: LW];
  end

  always_comb begin
    min_line = '1;
    for (int l = 0; l < LANES; l++)
      if (pend[l] && (line[l] < min_line)) min_line = line[l];
    for (int l = 0; l < LANES; l++)
      sel[l] = pend[l] && (line[l] == min_line);
  end
endmodule

// File: rtl/cwc_seg_fit.sv
module cwc_seg_fit
  import cwc_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES*7-1:0] offs_flat,
  input  logic [LANES-1:0]   sel,
  input  logic [1:0]         size_code,
  output logic [1:0]         seg_code,
  output logic [6:0]         seg_base_off
);
  logic [6:0] off [LANES];
  logic [6:0] lo, hi;
  seg_e       seg;

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign off[l] = offs_flat[l*7 +: 7];
  end

  // byte span covered by the selected lanes
  always_comb begin
    lo = 7'h7f;
    hi = 7'h00;
    for (int l = 0; l < LANES; l++) begin
      if (sel[l]) begin
        if (off[l] < lo) lo = off[l];
        if (last_off(off[l], size_code) > hi) hi = last_off(off[l], size_code);
      end
    end
  end

  assign seg          = seg_fit(lo, hi);
  assign seg_code     = seg;
  assign seg_base_off = seg_off(lo, seg);
endmodule

// File: rtl/cwc_coalescer.sv
module cwc_coalescer
  import cwc_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int GROUP  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  input  logic [1:0]              req_size,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [1:0]              txn_size,
  output logic [LANES-1:0]        txn_lanes,
  output logic                    txn_last,
  output logic                    done
);
  localparam int NG = LANES / GROUP;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;
  localparam int LW = ADDR_W - LINE_LG;

  state_e             st_q;
  logic [ADDR_W-1:0]  addr_q [LANES];
  logic [LANES-1:0]   mask_q, pend_q;
  logic [1:0]         size_q;
  logic [GW-1:0]      grp_q;
  logic               done_q;

  // named internal events
  logic               accept, scan_step, handoff, pick_found;
  logic [GW-1:0]      pick_idx;
  logic [GW:0]        pick_from;
  logic [NG-1:0]      grp_any;
  logic [LANES-1:0]   src_mask, sel, pend_after;
  logic [LW-1:0]      min_line;
  logic [6:0]         seg_base_off;
  logic [1:0]         seg_code;
  logic [LANES*LW-1:0] lines_flat;
  logic [LANES*7-1:0]  offs_flat;

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign scan_step  = (st_q == ST_SCAN);
  assign txn_valid  = (st_q == ST_EMIT);
  assign handoff    = txn_valid && txn_ready;
  assign pend_after = pend_q & ~sel;

  // group occupancy: incoming mask while idle, stored mask while scanning
  assign src_mask  = req_ready ? req_mask : mask_q;
  assign pick_from = req_ready ? '0 : ({1'b0, grp_q} + (GW+1)'(1));
  for (genvar g = 0; g < NG; g++) begin : g_any
    assign grp_any[g] = |src_mask[g*GROUP +: GROUP];
  end

  cwc_group_pick #(.NG(NG)) u_pick (
    .grp_any (grp_any),
    .from    (pick_from),
    .found   (pick_found),
    .idx     (pick_idx)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lines_flat[l*LW +: LW] = addr_q[l][ADDR_W-1:LINE_LG];
    assign offs_flat[l*7 +: 7]    = addr_q[l][LINE_LG-1:0];
  end

  cwc_line_min #(.LANES(LANES), .LW(LW)) u_min (
    .lines_flat (lines_flat),
    .pend       (pend_q),
    .min_line   (min_line),
    .sel        (sel)
  );

  cwc_seg_fit #(.LANES(LANES)) u_fit (
    .offs_flat    (offs_flat),
    .sel          (sel),
    .size_code    (size_q),
    .seg_code     (seg_code),
    .seg_base_off (seg_base_off)
  );

  assign txn_base  = {min_line, seg_base_off};
  assign txn_size  = seg_code;
  assign txn_lanes = sel;
  assign txn_last  = (pend_after == '0);
  assign done      = done_q;

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      pend_q <= '0;
      size_q <= '0;
      grp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          mask_q <= req_mask;
          size_q <= req_size;
          pend_q <= '0;
          if (pick_found) begin
            st_q  <= ST_SCAN;
            grp_q <= pick_idx;
          end else begin
            done_q <= 1'b1;
          end
        end
        ST_SCAN: begin
          for (int l = 0; l < LANES; l++)
            if (grp_q == GW'(l / GROUP)) pend_q[l] <= mask_q[l];
          if (pick_found) grp_q <= pick_idx;
          else            st_q  <= ST_EMIT;
        end
        ST_EMIT: if (handoff) begin
          pend_q <= pend_after;
          if (pend_after == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // lane address store, aligned to access width during the group's scan cycle
  for (genvar l = 0; l < LANES; l++) begin : g_addr
    always_ff @(posedge clk) begin
      if (accept)
        addr_q[l] <= req_addr[l*ADDR_W +: ADDR_W];
      else if (scan_step && (grp_q == GW'(l / GROUP)))
        addr_q[l] <= {addr_q[l][ADDR_W-1:3], addr_q[l][2:0] & ~low_mask(size_q)};
    end
  end

  // ordering tracker for the assertions
  logic              first_q;
  logic [ADDR_W-1:0] prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      prev_q  <= '0;
    end else if (accept) begin
      first_q <= 1'b1;
    end else if (handoff) begin
      first_q <= 1'b0;
      prev_q  <= txn_base;
    end
  end

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_size != 2'd3);

  p_base_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_base[4:0] == 5'd0) && (txn_size == 2'd0 || txn_base[5] == 1'b0)
                  && (txn_size != 2'd2 || txn_base[6] == 1'b0));

  p_lanes_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes != '0) && ((txn_lanes & ~mask_q) == '0));

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !first_q) |-> txn_base > prev_q);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> txn_valid && $stable(txn_base)
                                  && $stable(txn_size) && $stable(txn_lanes));

  p_empty_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mask == '0) |=> done && req_ready && !txn_valid);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff && txn_last) |=> done && req_ready);

endmodule

// File: tb/sim_cwc_coalescer.sv
module sim_cwc_coalescer;
  localparam int L = 32;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [L*AW-1:0] req_addr = '0;
  logic [L-1:0]    req_mask = '0;
  logic [1:0]      req_size = '0;
  logic            txn_valid;
  logic            txn_ready = 1'b1;
  logic [AW-1:0]   txn_base;
  logic [1:0]      txn_size;
  logic [L-1:0]    txn_lanes;
  logic            txn_last;
  logic            done;

  always #4 clk = ~clk;

  cwc_coalescer u0 (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  logic [AW-1:0] a [L];
  logic [AW-1:0] got_base [64];
  logic [1:0]    got_size [64];
  logic [L-1:0]  got_lanes [64];
  int            got_n, got_lat;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request, record descriptors, check handshake timing
  task automatic run(input logic [1:0] sz, input logic [L-1:0] m, input bit stall);
    bit held = 0;
    got_n = 0; got_lat = 0;
    @(negedge clk);
    for (int k = 0; k < L; k++) req_addr[k*AW +: AW] = a[k];
    req_size = sz; req_mask = m; req_valid = 1'b1;
    while (!req_ready) begin @(posedge clk); @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (m == '0) begin
      check(done && !txn_valid, "R9 done after empty accept", {done, txn_valid}, 2'b10);
      @(posedge clk); @(negedge clk);
      check(!done && !txn_valid, "R9 single done cycle", {done, txn_valid}, 2'b00);
      return;
    end
    while (!txn_valid && got_lat < 20) begin @(posedge clk); @(negedge clk); got_lat++; end
    for (int it = 0; it < 100; it++) begin
      if (!txn_valid) begin
        check(0, "R6 one descriptor per cycle", 0, 1);
        return;
      end
      check(!req_ready && !done, "R10 busy while emitting", {req_ready, done}, 2'b00);
      if (stall && !held) begin
        logic [AW-1:0] b0 = txn_base;
        logic [L-1:0]  l0 = txn_lanes;
        held = 1;
        txn_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          @(posedge clk); @(negedge clk);
          check(txn_valid && txn_base == b0 && txn_lanes == l0, "R7 stalled descriptor held",
                txn_base, b0);
        end
        txn_ready = 1'b1;
      end
      got_base[got_n] = txn_base; got_size[got_n] = txn_size; got_lanes[got_n] = txn_lanes;
      got_n++;
      if (txn_last) begin
        @(posedge clk); @(negedge clk);
        check(done && req_ready && !txn_valid, "R10 done after last handoff",
              {done, req_ready, txn_valid}, 3'b110);
        @(posedge clk); @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
        return;
      end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic expect_one(input string req, input int i, input logic [AW-1:0] b,
                            input logic [1:0] s, input logic [L-1:0] ln);
    check(got_base[i] == b, req, got_base[i], b);
    check(got_size[i] == s, req, got_size[i], s);
    check(got_lanes[i] == ln, req, got_lanes[i], ln);
  endtask

  task automatic fill(input logic [AW-1:0] base, input int step);
    for (int k = 0; k < L; k++) a[k] = base + AW'(k * step);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready && !txn_valid && !done, "R1 reset state", {req_ready, txn_valid, done}, 3'b100);
  endtask

  task automatic t_word_line;
    fill(32'h1000, 4);
    run(2'd2, 32'hffff_ffff, 0);
    check(got_n == 1, "R4 4-byte lanes one line", got_n, 1);
    expect_one("R5 full line", 0, 32'h1000, 2'd2, 32'hffff_ffff);
    check(got_lat == 4, "R8 four groups latency", got_lat, 4);
  endtask

  task automatic t_dword(input bit stall);
    fill(32'h2000, 8);
    run(2'd3, 32'hffff_ffff, stall);
    check(got_n == 2, "R4 8-byte lanes two lines", got_n, 2);
    expect_one("R6 first line lower", 0, 32'h2000, 2'd2, 32'h0000_ffff);
    expect_one("R6 second line", 1, 32'h2080, 2'd2, 32'hffff_0000);
  endtask

  task automatic t_small_segs;
    for (int k = 0; k < L; k++) a[k] = (k < 16) ? 32'h3040 + AW'(4 * k) : 32'hF000;
    run(2'd2, 32'h0000_00ff, 0);
    check(got_n == 1, "R4 inactive far lanes ignored", got_n, 1);
    expect_one("R5 32-byte segment", 0, 32'h3040, 2'd0, 32'h0000_00ff);
    check(got_lat == 1, "R8 one group latency", got_lat, 1);
    run(2'd2, 32'h0000_ffff, 0);
    expect_one("R5 64-byte segment", 0, 32'h3040, 2'd1, 32'h0000_ffff);
    check(got_lat == 2, "R8 two groups latency", got_lat, 2);
  endtask

  task automatic t_narrow;
    fill(32'h6000, 1);
    run(2'd0, 32'hffff_ffff, 0);
    expect_one("R2 byte lanes in 32 bytes", 0, 32'h6000, 2'd0, 32'hffff_ffff);
    fill(32'h6000, 2);
    run(2'd1, 32'hffff_ffff, 0);
    expect_one("R2 halfword lanes in 64 bytes", 0, 32'h6000, 2'd1, 32'hffff_ffff);
  endtask

  task automatic t_misaligned;
    fill(32'h0, 0);
    a[20] = 32'h5007;
    a[21] = 32'h503D;
    run(2'd3, 32'h0030_0000, 0);
    check(got_n == 1, "R2 misaligned lanes one line", got_n, 1);
    expect_one("R2 low bits ignored", 0, 32'h5000, 2'd1, 32'h0030_0000);
    check(got_lat == 1, "R8 lone group latency", got_lat, 1);
  endtask

  task automatic t_reverse;
    for (int k = 0; k < L; k++) a[k] = 32'h8000 + AW'((31 - k) * 128);
    run(2'd2, 32'hffff_ffff, 0);
    check(got_n == 32, "R4 thirty-two lines", got_n, 32);
    for (int j = 0; j < 32 && j < got_n; j++)
      expect_one("R6 ascending scatter", j, 32'h8000 + AW'(128 * j), 2'd0, 32'h1 << (31 - j));
  endtask

  task automatic t_group_skip;
    fill(32'h9000, 4);
    for (int k = 16; k < 24; k++) a[k] = 32'h9040 + AW'(4 * (k - 16));
    run(2'd2, 32'h00ff_00ff, 0);
    check(got_lat == 2, "R8 skipped empty groups", got_lat, 2);
    expect_one("R5 span needs 128", 0, 32'h9000, 2'd2, 32'h00ff_00ff);
  endtask

  task automatic t_two_ends;
    fill(32'h0, 0);
    a[0] = 32'hA100;
    a[31] = 32'hA000;
    run(2'd2, 32'h8000_0001, 0);
    check(got_n == 2, "R4 two separate lines", got_n, 2);
    expect_one("R6 lower line first", 0, 32'hA000, 2'd0, 32'h8000_0000);
    expect_one("R6 upper line second", 1, 32'hA100, 2'd0, 32'h0000_0001);
    check(got_lat == 2, "R8 end groups latency", got_lat, 2);
  endtask

  task automatic t_empty;
    fill(32'h4000, 4);
    run(2'd2, 32'h0, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_line();
    t_dword(0);
    t_small_segs();
    t_narrow();
    t_misaligned();
    t_reverse();
    t_group_skip();
    t_two_ends();
    t_empty();
    t_dword(1);
    finish_run();
  end
endmodule